// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits beside a single-issue pipeline and performs the architectural side of taking an exception. Each cycle the pipeline may present one request that carries the kind of exception, a load/store flag, the faulting virtual address, the id of a coprocessor, and the PC and next-PC of the faulting instruction. On an accepted request, a single clock edge updates the exception-level bit, the cause fields (code, delay-slot flag, coprocessor id), the exception PC, the bad-address register and the shadow-register-set control. On that same edge, the block emits a one-cycle redirect carrying the handler address, handler+4 and handler+8.

The handler address depends on the exception kind and on configuration inputs: the vector base, the boot-vector flag and the special-interrupt-vector flag. It also depends on the exception-level bit as it stood before this entry. A synchronous reset forces a redirect to the boot address and marks coprocessor 1 as usable. The vector base, boot-vector flag, interrupt-vector flag and exception shadow set are driven from outside the block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, every clock edge sets outputs as follows:
  - `redir_valid`=1, `redir_pc`=0xBFC00000, `redir_npc`=0xBFC00004, `redir_nnpc`=0xBFC00008.
  - `status_cu1`=1 and `status_exl`=0.
  - `epc`, `badvaddr`, the cause fields and both shadow-set fields are 0.
- R2: An accepted request loads `cause_code` from `exc_kind` and `exc_store`, using this kind encoding:
  - kind 0 interrupt → code 0x0; kind 1 TLB modified → 0x1.
  - kind 2 TLB refill and kind 3 TLB invalid → 0x2 on a load, 0x3 on a store.
  - kind 4 address error → 0x4 on a load, 0x5 on a store.
  - kind 5 syscall → 0x8; kind 6 breakpoint → 0x9; kind 7 reserved instruction → 0xA.
  - kind 8 coprocessor unusable → 0xB; kind 9 overflow → 0xC; kind 10 trap → 0xD.
- R3: A request is accepted when `exc_valid`=1, `rst`=0 and `exc_kind`≤10. On the next edge, `status_exl` becomes 1 whatever it was before, and `redir_valid` pulses high for exactly one cycle. A cycle with no accepted request leaves every register unchanged and drives `redir_valid` low.
- R4: When `exc_npc` differs from `exc_pc`+4, `epc` takes `exc_pc`−4 and `cause_bd` is set. Otherwise `epc` takes `exc_pc` and `cause_bd` is cleared.
- R5: `cause_ce` takes `exc_cop` for a coprocessor-unusable request and 0 for every other accepted request.
- R6: The general handler address is the upper bits of `ebase` (bits 31..12) with 0x180 in bits 11..0. The low 12 bits of `ebase` are ignored, and no carry passes above bit 11.
- R7: A TLB refill goes to offset 0x000 if `status_exl` was 0 before the entry, and to 0x180 otherwise.
- R8: An interrupt goes to offset 0x200 when `iv`=1, and to 0x180 when `iv`=0.
- R9: An overflow goes to the fixed address 0xBFC00200 when `bev`=1, and to the general vector when `bev`=0.
- R10: If `status_exl`=0 and `bev`=0 before an accepted entry, `srs_pss` takes the old `srs_css` and `srs_css` takes `ess`. Otherwise both fields hold.
- R11: `badvaddr` takes `exc_addr` only for kinds 1 to 4. Other accepted kinds leave it unchanged.
- R12: Reset wins over a request presented in the same cycle.
- R13: A request with `exc_kind` 11 to 15 is ignored, with no register change and no redirect.
- R14: Whenever `redir_valid` is high, `redir_npc` = `redir_pc`+4 and `redir_nnpc` = `redir_pc`+8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception request present |
| exc_kind | input | 4 | Exception kind (encoding in R2) |
| exc_store | input | 1 | Faulting access was a store |
| exc_addr | input | 32 | Faulting virtual address |
| exc_cop | input | 2 | Id of the unusable coprocessor |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_npc | input | 32 | Next-PC at the time of the fault |
| ebase | input | 32 | Exception vector base |
| bev | input | 1 | Boot exception vectors in use |
| iv | input | 1 | Special interrupt vector enable |
| ess | input | 4 | Shadow set selected for exceptions |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Redirect PC |
| redir_npc | output | 32 | Redirect next-PC |
| redir_nnpc | output | 32 | Redirect next-next-PC |
| status_exl | output | 1 | Exception-level bit |
| status_cu1 | output | 1 | Coprocessor-1 usable bit |
| cause_code | output | 5 | Exception code |
| cause_bd | output | 1 | Faulting instruction was in a delay slot |
| cause_ce | output | 2 | Coprocessor id for unusable faults |
| epc | output | 32 | Exception PC |
| badvaddr | output | 32 | Faulting virtual address register |
| srs_pss | output | 4 | Previous shadow set |
| srs_css | output | 4 | Current shadow set |

## Verification
The assertions assume two things about the inputs: they are settled before each rising edge, and `exc_pc` is word aligned, so the delay-slot test compares against a true sequential successor. The bench changes every input half a cycle away from the active edge. It uses only aligned PCs, and it gives a delay-slot next-PC that differs from `exc_pc`+4 by a multiple of four. Configuration inputs (`ebase`, `bev`, `iv`, `ess`) change only between requests. The properties that sample the pre-entry exception level therefore see the same settings the design used.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [3:0] {
    EK_INT          = 4'd0,
    EK_TLB_MOD      = 4'd1,
    EK_TLB_REFILL   = 4'd2,
    EK_TLB_INVALID  = 4'd3,
    EK_ADDR_ERR     = 4'd4,
    EK_SYSCALL      = 4'd5,
    EK_BREAK        = 4'd6,
    EK_RESV_INST    = 4'd7,
    EK_COP_UNUSABLE = 4'd8,
    EK_OVERFLOW     = 4'd9,
    EK_TRAP         = 4'd10
  } exc_kind_e;

  localparam int unsigned KIND_LAST = 10;

  function automatic logic kind_known(input logic [3:0] k);
    return k <= 4'(KIND_LAST);
  endfunction

  // Code written into the cause register; store flag splits the memory kinds.
  function automatic logic [4:0] code_for(input logic [3:0] k, input logic st);
    logic [4:0] c;
    case (k)
      EK_INT:          c = 5'h00;
      EK_TLB_MOD:      c = 5'h01;
      EK_TLB_REFILL,
      EK_TLB_INVALID:  c = st ? 5'h03 : 5'h02;
      EK_ADDR_ERR:     c = st ? 5'h05 : 5'h04;
      EK_SYSCALL:      c = 5'h08;
      EK_BREAK:        c = 5'h09;
      EK_RESV_INST:    c = 5'h0A;
      EK_COP_UNUSABLE: c = 5'h0B;
      EK_OVERFLOW:     c = 5'h0C;
      EK_TRAP:         c = 5'h0D;
      default:         c = 5'h1F;
    endcase
    return c;
  endfunction

  function automatic logic records_addr(input logic [3:0] k);
    return (k == EK_TLB_MOD) || (k == EK_TLB_REFILL) ||
           (k == EK_TLB_INVALID) || (k == EK_ADDR_ERR);
  endfunction

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter logic [XLEN-1:0] OVF_BOOT_VEC = 32'hBFC0_0200
) (
  input  logic [3:0]      kind,
  input  logic [XLEN-1:0] ebase,
  input  logic            exl_before,
  input  logic            bev,
  input  logic            iv,
  output logic [XLEN-1:0] handler
);
  localparam logic [PAGE_BITS-1:0] OFF_REFILL  = PAGE_BITS'(12'h000);
  localparam logic [PAGE_BITS-1:0] OFF_GENERAL = PAGE_BITS'(12'h180);
  localparam logic [PAGE_BITS-1:0] OFF_IRQ_VEC = PAGE_BITS'(12'h200);

  logic [PAGE_BITS-1:0] offset;

  always_comb begin
    offset = OFF_GENERAL;
    if (kind == EK_TLB_REFILL && !exl_before) offset = OFF_REFILL;
    else if (kind == EK_INT && iv)            offset = OFF_IRQ_VEC;
  end

  always_comb begin
    if (kind == EK_OVERFLOW && bev) handler = OVF_BOOT_VEC;
    else                            handler = {ebase[XLEN-1:PAGE_BITS], offset};
  end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INST_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] npc,
  output logic [XLEN-1:0] epc_next,
  output logic            in_slot
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INST_BYTES);

  always_comb begin
    in_slot  = (npc != pc + STEP);
    epc_next = in_slot ? pc - STEP : pc;
  end
endmodule

// File: rtl/exc_srs_rotate.sv
module exc_srs_rotate #(
  parameter int unsigned SRS_W = 4
) (
  input  logic [SRS_W-1:0] pss,
  input  logic [SRS_W-1:0] css,
  input  logic [SRS_W-1:0] ess,
  input  logic             exl_before,
  input  logic             bev,
  output logic [SRS_W-1:0] pss_next,
  output logic [SRS_W-1:0] css_next
);
  logic rotate;

  always_comb begin
    rotate   = !exl_before && !bev;
    pss_next = rotate ? css : pss;
    css_next = rotate ? ess : css;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INST_BYTES = 4,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned CE_W       = 2,
  parameter int unsigned SRS_W      = 4,
  parameter logic [XLEN-1:0] BOOT_VEC     = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] OVF_BOOT_VEC = 32'hBFC0_0200
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_valid,
  input  logic [3:0]      exc_kind,
  input  logic            exc_store,
  input  logic [XLEN-1:0] exc_addr,
  input  logic [CE_W-1:0] exc_cop,
  input  logic [XLEN-1:0] exc_pc,
  input  logic [XLEN-1:0] exc_npc,
  input  logic [XLEN-1:0] ebase,
  input  logic            bev,
  input  logic            iv,
  input  logic [SRS_W-1:0] ess,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic [XLEN-1:0] redir_npc,
  output logic [XLEN-1:0] redir_nnpc,
  output logic            status_exl,
  output logic            status_cu1,
  output logic [4:0]      cause_code,
  output logic            cause_bd,
  output logic [CE_W-1:0] cause_ce,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] badvaddr,
  output logic [SRS_W-1:0] srs_pss,
  output logic [SRS_W-1:0] srs_css
);
  localparam logic [XLEN-1:0] STEP1 = XLEN'(INST_BYTES);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * INST_BYTES);

  logic             accept;
  logic [XLEN-1:0]  handler;
  logic [XLEN-1:0]  epc_next;
  logic             in_slot;
  logic [SRS_W-1:0] pss_next;
  logic [SRS_W-1:0] css_next;

  assign accept = exc_valid && kind_known(exc_kind);

  exc_vector_sel #(
    .XLEN(XLEN), .PAGE_BITS(PAGE_BITS), .OVF_BOOT_VEC(OVF_BOOT_VEC)
  ) u_vec (
    .kind(exc_kind), .ebase(ebase), .exl_before(status_exl),
    .bev(bev), .iv(iv), .handler(handler)
  );

  exc_epc_calc #(.XLEN(XLEN), .INST_BYTES(INST_BYTES)) u_epc (
    .pc(exc_pc), .npc(exc_npc), .epc_next(epc_next), .in_slot(in_slot)
  );

  exc_srs_rotate #(.SRS_W(SRS_W)) u_srs (
    .pss(srs_pss), .css(srs_css), .ess(ess), .exl_before(status_exl),
    .bev(bev), .pss_next(pss_next), .css_next(css_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b1;
      redir_pc    <= BOOT_VEC;
      redir_npc   <= BOOT_VEC + STEP1;
      redir_nnpc  <= BOOT_VEC + STEP2;
      status_exl  <= 1'b0;
      status_cu1  <= 1'b1;
      cause_code  <= '0;
      cause_bd    <= 1'b0;
      cause_ce    <= '0;
      epc         <= '0;
      badvaddr    <= '0;
      srs_pss     <= '0;
      srs_css     <= '0;
    end else if (accept) begin
      redir_valid <= 1'b1;
      redir_pc    <= handler;
      redir_npc   <= handler + STEP1;
      redir_nnpc  <= handler + STEP2;
      status_exl  <= 1'b1;
      cause_code  <= code_for(exc_kind, exc_store);
      cause_bd    <= in_slot;
      cause_ce    <= (exc_kind == EK_COP_UNUSABLE) ? exc_cop : '0;
      epc         <= epc_next;
      if (records_addr(exc_kind)) badvaddr <= exc_addr;
      srs_pss     <= pss_next;
      srs_css     <= css_next;
    end else begin
      redir_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned CE_W  = 2,
  parameter int unsigned SRS_W = 4,
  parameter logic [XLEN-1:0] BOOT_VEC     = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] OVF_BOOT_VEC = 32'hBFC0_0200
) (
  input logic            clk,
  input logic            rst,
  input logic            exc_valid,
  input logic [3:0]      exc_kind,
  input logic [XLEN-1:0] exc_pc,
  input logic [XLEN-1:0] exc_npc,
  input logic            bev,
  input logic [SRS_W-1:0] ess,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_pc,
  input logic [XLEN-1:0] redir_npc,
  input logic [XLEN-1:0] redir_nnpc,
  input logic            status_exl,
  input logic            status_cu1,
  input logic            cause_bd,
  input logic [XLEN-1:0] epc,
  input logic [SRS_W-1:0] srs_pss,
  input logic [SRS_W-1:0] srs_css
);
  logic taken;
  assign taken = exc_valid && (exc_kind <= 4'd10);

  a_r1_boot_redirect: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> redir_valid && redir_pc == BOOT_VEC && status_cu1 && !status_exl);

  a_r3_exl_set: assert property (@(posedge clk) disable iff (rst)
    taken |=> status_exl && redir_valid);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !taken |=> !redir_valid && $stable(epc) && $stable(status_exl));

  a_r4_delay_slot: assert property (@(posedge clk) disable iff (rst)
    taken && exc_npc != exc_pc + 32'd4 |=> cause_bd && epc == $past(exc_pc) - 32'd4);

  a_r9_ovf_boot: assert property (@(posedge clk) disable iff (rst)
    taken && exc_kind == 4'd9 && bev |=> redir_pc == OVF_BOOT_VEC);

  a_r10_rotate: assert property (@(posedge clk) disable iff (rst)
    taken && !status_exl && !bev |=> srs_pss == $past(srs_css) && srs_css == $past(ess));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    taken && (status_exl || bev) |=> $stable(srs_pss) && $stable(srs_css));

  a_r14_successors: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> redir_npc == redir_pc + 32'd4 && redir_nnpc == redir_pc + 32'd8);
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN(XLEN), .CE_W(CE_W), .SRS_W(SRS_W),
  .BOOT_VEC(BOOT_VEC), .OVF_BOOT_VEC(OVF_BOOT_VEC)
) u_chk (
  .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_kind(exc_kind),
  .exc_pc(exc_pc), .exc_npc(exc_npc), .bev(bev), .ess(ess),
  .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_npc(redir_npc),
  .redir_nnpc(redir_nnpc), .status_exl(status_exl), .status_cu1(status_cu1),
  .cause_bd(cause_bd), .epc(epc), .srs_pss(srs_pss), .srs_css(srs_css)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_kind = '0;
  logic        exc_store = 1'b0;
  logic [31:0] exc_addr = '0;
  logic [1:0]  exc_cop = '0;
  logic [31:0] exc_pc = 32'h0000_1000;
  logic [31:0] exc_npc = 32'h0000_1004;
  logic [31:0] ebase = 32'h8000_0000;
  logic        bev = 1'b0;
  logic        iv = 1'b0;
  logic [3:0]  ess = '0;

  logic        redir_valid, status_exl, status_cu1, cause_bd;
  logic [31:0] redir_pc, redir_npc, redir_nnpc, epc, badvaddr;
  logic [4:0]  cause_code;
  logic [1:0]  cause_ce;
  logic [3:0]  srs_pss, srs_css;

  exc_entry_ctrl u0 (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_kind(exc_kind),
    .exc_store(exc_store), .exc_addr(exc_addr), .exc_cop(exc_cop),
    .exc_pc(exc_pc), .exc_npc(exc_npc), .ebase(ebase), .bev(bev), .iv(iv),
    .ess(ess), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .redir_npc(redir_npc), .redir_nnpc(redir_nnpc), .status_exl(status_exl),
    .status_cu1(status_cu1), .cause_code(cause_code), .cause_bd(cause_bd),
    .cause_ce(cause_ce), .epc(epc), .badvaddr(badvaddr),
    .srs_pss(srs_pss), .srs_css(srs_css)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // Behavioural reference state
  bit          m_valid, m_exl, m_cu1, m_bd;
  int unsigned m_pc, m_epc, m_badv;
  int          m_code, m_ce, m_pss, m_css;

  function automatic int exp_code(int k, bit st);
    case (k)
      0: return 0;   1: return 1;
      2, 3: return st ? 3 : 2;
      4: return st ? 5 : 4;
      5: return 8;   6: return 9;   7: return 10;
      8: return 11;  9: return 12;  default: return 13;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1; m_pc <= 32'hBFC0_0000; m_exl <= 0; m_cu1 <= 1;
      m_code <= 0; m_bd <= 0; m_ce <= 0; m_epc <= 0; m_badv <= 0;
      m_pss <= 0; m_css <= 0;
    end else if (exc_valid && exc_kind <= 10) begin
      int unsigned base;
      base = ebase & 32'hFFFF_F000;
      m_valid <= 1;
      if (exc_kind == 9 && bev)          m_pc <= 32'hBFC0_0200;
      else if (exc_kind == 2 && !m_exl)  m_pc <= base;
      else if (exc_kind == 0 && iv)      m_pc <= base + 32'h200;
      else                               m_pc <= base + 32'h180;
      m_exl  <= 1;
      m_code <= exp_code(int'(exc_kind), exc_store);
      m_bd   <= (exc_npc != exc_pc + 4);
      m_epc  <= (exc_npc != exc_pc + 4) ? exc_pc - 4 : exc_pc;
      m_ce   <= (exc_kind == 8) ? int'(exc_cop) : 0;
      if (exc_kind >= 1 && exc_kind <= 4) m_badv <= exc_addr;
      if (!m_exl && !bev) begin m_pss <= m_css; m_css <= int'(ess); end
    end else begin
      m_valid <= 0;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(tag,  "redir_valid", redir_valid, m_valid);
    chk(tag,  "redir_pc", redir_pc, m_pc);
    if (m_valid) begin
      chk("R14", "redir_npc", redir_npc, longint'(m_pc) + 4);
      chk("R14", "redir_nnpc", redir_nnpc, longint'(m_pc) + 8);
    end
    chk("R3",  "status_exl", status_exl, m_exl);
    chk("R1",  "status_cu1", status_cu1, m_cu1);
    chk("R2",  "cause_code", cause_code, m_code);
    chk("R4",  "cause_bd", cause_bd, m_bd);
    chk("R4",  "epc", epc, m_epc);
    chk("R5",  "cause_ce", cause_ce, m_ce);
    chk("R11", "badvaddr", badvaddr, m_badv);
    chk("R10", "srs_pss", srs_pss, m_pss);
    chk("R10", "srs_css", srs_css, m_css);
  end

  task automatic req(input string t, input int k, input bit st, input int unsigned a,
                     input int unsigned pc, input int unsigned npc, input int cop);
    @(negedge clk); #1;
    tag = t; rst = 0; exc_valid = 1; exc_kind = 4'(k); exc_store = st;
    exc_addr = a; exc_pc = pc; exc_npc = npc; exc_cop = 2'(cop);
    @(negedge clk); #1;
    exc_valid = 0;
  endtask

  task automatic do_reset(input string t);
    @(negedge clk); #1;
    tag = t; rst = 1; exc_valid = 0;
    repeat (2) @(negedge clk);
    #1; rst = 0;
  endtask

  task automatic idle(input string t, input int n);
    @(negedge clk); #1; tag = t; exc_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset("R1");
    // R7: refill with EXL clear, then with EXL set; R10 rotation with ess=5
    ess = 4'd5;
    req("R7", 2, 0, 32'h0040_0010, 32'h0000_2000, 32'h0000_2004, 0);
    req("R7", 2, 1, 32'h0040_0020, 32'h0000_2010, 32'h0000_2014, 0);
    idle("R3", 2);
    // R2: each kind, load and store
    for (int k = 0; k <= 10; k++) begin
      req("R2", k, 0, 32'h1000_0000 + k, 32'h0000_3000 + 16*k, 32'h0000_3004 + 16*k, 1);
      req("R2", k, 1, 32'h2000_0000 + k, 32'h0000_3100 + 16*k, 32'h0000_3104 + 16*k, 2);
    end
    // R4: delay slot, then sequential
    req("R4", 5, 0, 0, 32'h0000_5008, 32'h0000_6000, 0);
    req("R4", 6, 0, 0, 32'h0000_5008, 32'h0000_500C, 0);
    // R5: coprocessor id then cleared
    req("R5", 8, 0, 0, 32'h0000_7000, 32'h0000_7004, 3);
    req("R5", 10, 0, 0, 32'h0000_7010, 32'h0000_7014, 3);
    // R6: low bits of ebase ignored
    ebase = 32'h9000_0FFF;
    req("R6", 5, 0, 0, 32'h0000_8000, 32'h0000_8004, 0);
    // R8: interrupt vectors
    iv = 1; req("R8", 0, 0, 0, 32'h0000_8100, 32'h0000_8104, 0);
    iv = 0; req("R8", 0, 0, 0, 32'h0000_8200, 32'h0000_8204, 0);
    // R9: overflow with and without boot vectors
    bev = 1; req("R9", 9, 0, 0, 32'h0000_8300, 32'h0000_8304, 0);
    bev = 0; req("R9", 9, 0, 0, 32'h0000_8400, 32'h0000_8404, 0);
    // R11: address written, then kept by a syscall
    req("R11", 4, 1, 32'hDEAD_BEE0, 32'h0000_8500, 32'h0000_8504, 0);
    req("R11", 5, 0, 32'h1234_5678, 32'h0000_8600, 32'h0000_8604, 0);
    // R13: unknown kinds ignored
    for (int k = 11; k <= 15; k++)
      req("R13", k, 1, 32'hFFFF_0000, 32'h0000_9000, 32'h0000_A000, 3);
    // R10: rotation blocked by bev after reset
    do_reset("R1");
    bev = 1; ess = 4'd9;
    req("R10", 5, 0, 0, 32'h0000_B000, 32'h0000_B004, 0);
    bev = 0;
    do_reset("R1");
    ess = 4'd7;
    req("R10", 6, 0, 0, 32'h0000_B100, 32'h0000_B104, 0);
    ess = 4'd3;
    req("R10", 6, 0, 0, 32'h0000_B200, 32'h0000_B204, 0);
    // R12: reset together with a request
    @(negedge clk); #1;
    tag = "R12"; rst = 1; exc_valid = 1; exc_kind = 4'd5;
    @(negedge clk); #1;
    rst = 0; exc_valid = 0;
    idle("R3", 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule